// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides who owns the local bus: the internal bus interface, or an external master that asks for the bus with a level-sensitive hold request. The request first passes through a synchronizer. The arbiter then waits until the bus is quiet: no bus cycle is running, no locked sequence is open, no DMA sequence is in progress and no refresh is pending. Only then does it acknowledge the request. While the bus is handed over, it tells the pad drivers to float and forces every chip select to its inactive high level.

Memory refresh outranks the external master. If a refresh becomes due while the bus is granted, the acknowledge is withdrawn at once. The bus stays floated until the external master lets its request go. The float is then released, and the refresh grant follows in the same cycle. An ordinary release of the request drops the acknowledge and returns the bus to internal ownership.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While reset is active, hold_ack and cs_force_high are low and bus_float is high.
- R2: hold_ack rises only at a clock edge where cycle_busy, locked_seq, dma_active and refresh_req were all low.
- R3: With the bus quiet and the bus owned internally, hold_ack rises exactly SYNC_STAGES+1 clock edges after the first edge that samples hold_req high.
- R4: Whenever hold_ack is high, bus_float and cs_force_high are both high.
- R5: While the bus is owned internally, a high refresh_req drives refresh_gnt high in the same cycle and stops a pending hold from being granted. refresh_gnt is never high together with hold_ack or bus_float.
- R6: If refresh_req is high while the bus is granted and the synchronized hold is still high, hold_ack falls at the next edge and bus_float and cs_force_high stay high.
- R7: After a refresh has withdrawn the grant, hold_ack stays low and bus_float stays high until the synchronized hold is low. At the next edge after that, bus_float and cs_force_high fall.
- R8: When the synchronized hold goes low during a grant, hold_ack, bus_float and cs_force_high all fall at the next edge.
- R9: When the bus is reclaimed for a refresh and refresh_req is still high, refresh_gnt is high in the first cycle in which bus_float is low.
- R10: A high locked_seq holds off hold_ack for its whole duration, however long hold_req stays high.
- R11: A high dma_active holds off hold_ack until the DMA sequence ends. cycle_busy likewise defers the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | Level-sensitive bus request from the external master |
| cycle_busy | input | 1 | A bus cycle is in progress |
| locked_seq | input | 1 | A locked transfer sequence is open |
| dma_active | input | 1 | A multi-cycle DMA sequence has started |
| refresh_req | input | 1 | A memory refresh is due |
| hold_ack | output | 1 | Bus granted to the external master |
| bus_float | output | 1 | Address, data, status, direction and strobe drivers go high-impedance |
| cs_force_high | output | 1 | Force all chip selects to their inactive high level |
| refresh_gnt | output | 1 | Refresh may use the bus |

## Verification
The assertions check the following on every cycle:
- the acknowledge only ever rises out of a quiet bus;
- float and the chip-select force always cover the grant;
- refresh is withdrawn from the bus early and the bus is then held;
- a release is followed by the bus being reclaimed;
- the refresh grant never overlaps a floated bus.

Some behaviour only the bench's scenarios can show. These are the exact synchronizer latency, a long locked or DMA sequence that defers the grant, and the refresh grant appearing once a refresh reclaim completes. They are covered by directed sequences, followed by a long constrained-random run compared against a cycle model.

// File: rtl/bha_pkg.sv
package bha_pkg;

   typedef enum logic [1:0] {
      ST_OWN     = 2'd0,
      ST_GRANT   = 2'd1,
      ST_RECLAIM = 2'd2
   } arb_state_t;

   localparam int NUM_BLOCKERS = 3;

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bha_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bha_quiet.sv
module bha_quiet #(
   parameter int WIDTH = 3
) (
   input  logic [WIDTH-1:0] blockers,
   output logic             quiet
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("bha_quiet: WIDTH must be positive");
      end
   endgenerate

   assign quiet = ~|blockers;
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
   import bha_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hold_s,
   input  logic quiet,
   input  logic refresh_req,
   output logic hold_ack,
   output logic bus_float,
   output logic cs_force_high,
   output logic refresh_gnt
);
   arb_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OWN: begin
            if (!refresh_req && hold_s && quiet) state_d = ST_GRANT;
         end
         ST_GRANT: begin
            if (!hold_s)          state_d = ST_OWN;
            else if (refresh_req) state_d = ST_RECLAIM;
         end
         ST_RECLAIM: begin
            if (!hold_s) state_d = ST_OWN;
         end
         default: state_d = ST_OWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_OWN;
      else        state_q <= state_d;
   end

   assign hold_ack      = (state_q == ST_GRANT);
   assign cs_force_high = (state_q != ST_OWN);
   assign bus_float     = (state_q != ST_OWN) || !rst_n;
   assign refresh_gnt   = (state_q == ST_OWN) && refresh_req && rst_n;
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_req,
   input  logic cycle_busy,
   input  logic locked_seq,
   input  logic dma_active,
   input  logic refresh_req,
   output logic hold_ack,
   output logic bus_float,
   output logic cs_force_high,
   output logic refresh_gnt
);
   localparam int NB = bha_pkg::NUM_BLOCKERS;

   logic          hold_s;
   logic          quiet;
   logic [NB-1:0] blockers;

   assign blockers = {dma_active, locked_seq, cycle_busy};

   bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (hold_req),
      .q    (hold_s)
   );

   bha_quiet #(.WIDTH(NB)) u_quiet (
      .blockers(blockers),
      .quiet   (quiet)
   );

   bha_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .hold_s       (hold_s),
      .quiet        (quiet),
      .refresh_req  (refresh_req),
      .hold_ack     (hold_ack),
      .bus_float    (bus_float),
      .cs_force_high(cs_force_high),
      .refresh_gnt  (refresh_gnt)
   );
endmodule

// File: rtl/bha_checker.sv
module bha_checker (
   input logic clk,
   input logic rst_n,
   input logic hold_s,
   input logic cycle_busy,
   input logic locked_seq,
   input logic dma_active,
   input logic refresh_req,
   input logic hold_ack,
   input logic bus_float,
   input logic cs_force_high,
   input logic refresh_gnt
);
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |-> (bus_float && !hold_ack && !cs_force_high));

   p_grant_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_ack) |-> $past(!cycle_busy && !locked_seq && !dma_active && !refresh_req));

   p_grant_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack |-> (bus_float && cs_force_high));

   p_refresh_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_gnt |-> (!hold_ack && !bus_float));

   p_revoke_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ack && hold_s && refresh_req) |=> (!hold_ack && bus_float && cs_force_high));

   p_reclaim_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_float && !hold_ack && hold_s) |=> (!hold_ack && bus_float));

   p_reclaim_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_float && !hold_ack && !hold_s) |=> (!bus_float && !cs_force_high));

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_ack && !hold_s) |=> (!hold_ack && !bus_float && !cs_force_high));

   p_refresh_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_float) && refresh_req) |-> refresh_gnt);

   p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_ack && locked_seq) |=> !hold_ack);

   p_dma_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_ack && dma_active) |=> !hold_ack);
endmodule

bind bus_hold_arbiter bha_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hold_s       (hold_s),
   .cycle_busy   (cycle_busy),
   .locked_seq   (locked_seq),
   .dma_active   (dma_active),
   .refresh_req  (refresh_req),
   .hold_ack     (hold_ack),
   .bus_float    (bus_float),
   .cs_force_high(cs_force_high),
   .refresh_gnt  (refresh_gnt)
);

// File: tb/bus_hold_arbiter_test.sv
module bus_hold_arbiter_test;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_req = 1'b0, cycle_busy = 1'b0, locked_seq = 1'b0;
   logic dma_active = 1'b0, refresh_req = 1'b0;
   logic hold_ack, bus_float, cs_force_high, refresh_gnt;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   // bench model: 0 own, 1 granted, 2 reclaiming for refresh
   int         m_state = 0;
   logic [SYNC-1:0] m_sync = '0;

   always #5 clk = ~clk;

   bus_hold_arbiter #(.SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cycle_busy(cycle_busy),
      .locked_seq(locked_seq), .dma_active(dma_active), .refresh_req(refresh_req),
      .hold_ack(hold_ack), .bus_float(bus_float), .cs_force_high(cs_force_high),
      .refresh_gnt(refresh_gnt)
   );

   function automatic int next_state(int st, logic hs, logic quiet, logic rf);
      case (st)
         0: return (!rf && hs && quiet) ? 1 : 0;
         1: return !hs ? 0 : (rf ? 2 : 1);
         default: return !hs ? 0 : 2;
      endcase
   endfunction

   task automatic check(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      check(tag, "hold_ack", hold_ack, m_state == 1);
      check(tag, "bus_float", bus_float, m_state != 0);
      check(tag, "cs_force_high", cs_force_high, m_state != 0);
      check(tag, "refresh_gnt", refresh_gnt, (m_state == 0) && refresh_req);
   endtask

   // called at a falling edge: drive, advance model over the next rising edge, compare
   task automatic step(logic h, logic b, logic l, logic d, logic r, string tag);
      hold_req = h; cycle_busy = b; locked_seq = l; dma_active = d; refresh_req = r;
      m_state = next_state(m_state, m_sync[SYNC-1], !(b || l || d), r);
      m_sync  = {m_sync[SYNC-2:0], h};
      @(negedge clk);
      compare(tag);
   endtask

   task automatic settle();
      for (int i = 0; i < SYNC + 2; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state
      @(negedge clk);
      check("R1", "hold_ack", hold_ack, 1'b0);
      check("R1", "bus_float", bus_float, 1'b1);
      check("R1", "cs_force_high", cs_force_high, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R3: exact synchronizer latency
      settle();
      begin
         int first = -1;
         for (int i = 1; i <= SYNC + 3; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
            if (hold_ack && first < 0) first = i;
         end
         check("R3", "latency ok", first == SYNC + 1, 1'b1);
      end
      // R8: release
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      for (int i = 0; i < SYNC; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      check("R8", "hold_ack", hold_ack, 1'b0);

      // R10: long locked sequence defers the grant
      settle();
      for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
      check("R10", "hold_ack during lock", hold_ack, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
      check("R10", "hold_ack after lock", hold_ack, 1'b1);

      // R11: DMA and busy cycle defer the grant
      settle();
      for (int i = 0; i < 16; i++) step(1'b1, i < 4, 1'b0, 1'b1, 1'b0, "R11");
      check("R11", "hold_ack during dma", hold_ack, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
      check("R11", "hold_ack during busy", hold_ack, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
      check("R11", "hold_ack after dma", hold_ack, 1'b1);

      // R6 / R7 / R9: refresh withdraws a live grant
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
      check("R6", "hold_ack dropped", hold_ack, 1'b0);
      check("R6", "bus_float kept", bus_float, 1'b1);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
      check("R7", "bus_float held", bus_float, 1'b1);
      for (int i = 0; i < SYNC + 1; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
      check("R9", "refresh_gnt", refresh_gnt, 1'b1);
      check("R9", "bus_float", bus_float, 1'b0);

      // R5: pending refresh outranks a waiting hold
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
      check("R5", "hold_ack", hold_ack, 1'b0);
      check("R5", "refresh_gnt", refresh_gnt, 1'b1);

      // R2 / R4: constrained random against the model
      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 10) < 7, ($urandom % 10) < 3, ($urandom % 10) < 1,
              ($urandom % 10) < 2, ($urandom % 10) < 1, "R2");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule